// File: doc/BRIEF.md
# Clock-Configuration SMBus Block-Write Target

This block is the configuration port of a clock generator. It listens on a two-wire SMBus, oversamples SCL and SDA on a fast system clock, and picks out start and stop conditions. It understands one kind of transfer, a block write. The transfer carries a fixed device address with the write direction, a command byte that must be zero, a byte count, and then the payload. Payload bytes always land in the clock-control registers starting at register 0 and moving upward. No register index is ever sent.

The target acknowledges a byte by pulling SDA low through an open-drain output enable during the ninth clock. If any header byte is wrong, the target sends no acknowledge and stays silent until the next start. Every register has a power-on default and a mask of writable bits. Register 0 also shows three read-only status fields: the live CPU-stop pin, the two strap pins captured during reset, and a constant 1. The full register image is a flat output that feeds the clock-gating logic.

Top module: `clkcfg_smbus_target`

## Requirements
- R1: In reset and right after it, the image holds these defaults (register: value): 1: 07h, 2: 7Fh, 3: C7h, 4: 3Fh, 5: 00h. Register 0 holds 0 in all of its writable bits 7, 5 and 3.
- R2: The first byte after a start is acknowledged only when it is D2h (address 69h, R/W = 0). Any other value, including D3h, is not acknowledged, and no later byte is acknowledged or written until the next start.
- R3: The second byte must be 00h. Any other command byte is not acknowledged, and the rest of the transfer is ignored.
- R4: The third byte is a count. Values 1 to 32 are acknowledged. The values 0 and anything above 32 are not acknowledged, and the rest of the transfer is ignored.
- R5: Payload byte k (k from 0) is shifted in MSB first and written to register k. Only the writable bits change. The writable masks are: 0: A8h, 1: 7Fh, 2: 7Fh, 3: FFh, 4: 3Fh, 5: 3Fh.
- R6: A stop after any complete byte ends the transfer. Bytes already acknowledged stay written. The next transfer fills from register 0 again.
- R7: Payload bytes within the count but beyond register 5 are acknowledged and discarded. Bytes beyond the count are not acknowledged and change nothing.
- R8: Register 0 bit 4 follows the live stop pin. Bits 2:1 show the straps captured while reset is high and do not follow later strap changes. Bit 0 reads 1.
- R9: SDA is driven only during the acknowledge clock. The output enable changes only while SCL is low and is released after the ninth SCL fall.
- R10: A repeated start at any point restarts address decoding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x SCL |
| rst | input | 1 | Synchronous active-high reset; straps are captured while it is high |
| scl_i | input | 1 | SMBus clock line |
| sda_i | input | 1 | SMBus data line as seen on the wire |
| sda_oe_o | output | 1 | Open-drain pull-down enable for SDA (1 = drive low) |
| stop_pin_n_i | input | 1 | Live CPU-stop pin, shown in register 0 bit 4 |
| strap_i | input | 2 | Frequency/mode straps, captured in reset |
| cfg_o | output | 48 | Register image, register k at bits 8k+7:8k |

## Verification
The bench sweeps the byte count from 1 to 8 and also runs the full count of 32. A design that indexed off the count, wrapped its register pointer, or refused bytes past the register bank would then leave the wrong bytes in the image or drop an acknowledge. Bad addresses (including the read direction), bad commands, and counts of 0, 33 and FFh are each followed by extra payload. A target that resumed decoding after a NACK would acknowledge that payload or corrupt registers. An early stop, a byte past the count, repeated starts (both mid-header and after a rejected address), and strap changes after reset are also covered. These catch designs that commit late, overrun the count, miss restarts, or sample the straps live.

// File: rtl/cfg_pkg.sv
package cfg_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_CMD,
        ST_COUNT,
        ST_DATA,
        ST_IGNORE
    } st_e;

    // Per-byte verdict at the end of eight data bits.
    typedef struct packed {
        logic ack;
        st_e  nxt;
    } dec_t;

    // Conditions seen on the synchronised bus.
    typedef struct packed {
        logic sda;
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
    } bus_ev_t;

    localparam logic [7:0] CMD_CODE = 8'h00;

    function automatic logic [7:0] reg_default(int idx);
        case (idx)
            1:       return 8'h07;
            2:       return 8'h7F;
            3:       return 8'hC7;
            4:       return 8'h3F;
            default: return 8'h00;
        endcase
    endfunction

    function automatic logic [7:0] reg_wmask(int idx);
        case (idx)
            0:       return 8'hA8;
            1, 2:    return 8'h7F;
            3:       return 8'hFF;
            4, 5:    return 8'h3F;
            default: return 8'hFF;
        endcase
    endfunction

endpackage

// File: rtl/cfg_bus_sync.sv
module cfg_bus_sync
    import cfg_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    scl_i,
    input  logic    sda_i,
    output bus_ev_t ev
);
    logic [STAGES-1:0] scl_sh, sda_sh;
    logic scl_q, sda_q, scl_s, sda_s;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_sh <= '1;
            sda_sh <= '1;
            scl_q  <= 1'b1;
            sda_q  <= 1'b1;
        end else begin
            scl_sh <= {scl_sh[STAGES-2:0], scl_i};
            sda_sh <= {sda_sh[STAGES-2:0], sda_i};
            scl_q  <= scl_s;
            sda_q  <= sda_s;
        end
    end

    assign scl_s = scl_sh[STAGES-1];
    assign sda_s = sda_sh[STAGES-1];

    always_comb begin
        ev.sda      = sda_s;
        ev.scl_rise = scl_s & ~scl_q;
        ev.scl_fall = ~scl_s & scl_q;
        ev.start    = scl_s & scl_q & sda_q & ~sda_s;
        ev.stop     = scl_s & scl_q & ~sda_q & sda_s;
    end
endmodule

// File: rtl/cfg_byte_engine.sv
module cfg_byte_engine
    import cfg_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR  = 7'h69,
    parameter int         MAX_COUNT = 32,
    parameter int         NUM_REGS  = 6,
    parameter int         CW        = 6
) (
    input  logic          clk,
    input  logic          rst,
    input  bus_ev_t       ev,
    output st_e           st_o,
    output logic          sda_oe,
    output logic          wr_en,
    output logic [CW-1:0] wr_idx,
    output logic [7:0]    wr_data
);
    st_e           st, pend;
    logic [7:0]    shreg;
    logic [3:0]    bitcnt;
    logic          in_ack;
    logic [CW-1:0] remain, idx;
    logic          byte_done;
    dec_t          dec;

    assign byte_done = ev.scl_fall && !in_ack && bitcnt == 4'd8
                       && !ev.start && !ev.stop
                       && st != ST_IDLE && st != ST_IGNORE;

    always_comb begin
        dec = '{ack: 1'b0, nxt: ST_IGNORE};
        case (st)
            ST_ADDR:  if (shreg == {DEV_ADDR, 1'b0}) dec = '{ack: 1'b1, nxt: ST_CMD};
            ST_CMD:   if (shreg == CMD_CODE)         dec = '{ack: 1'b1, nxt: ST_COUNT};
            ST_COUNT: if (shreg != 8'h00 && int'(shreg) <= MAX_COUNT)
                                                     dec = '{ack: 1'b1, nxt: ST_DATA};
            ST_DATA:  if (remain != '0)              dec = '{ack: 1'b1, nxt: ST_DATA};
            default: ;
        endcase
    end

    assign wr_en   = byte_done && st == ST_DATA && remain != '0
                     && int'(idx) < NUM_REGS;
    assign wr_idx  = idx;
    assign wr_data = shreg;
    assign st_o    = st;

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= ST_IDLE;
            pend   <= ST_IDLE;
            shreg  <= '0;
            bitcnt <= '0;
            in_ack <= 1'b0;
            sda_oe <= 1'b0;
            remain <= '0;
            idx    <= '0;
        end else if (ev.start) begin
            st     <= ST_ADDR;
            bitcnt <= '0;
            in_ack <= 1'b0;
            sda_oe <= 1'b0;
        end else if (ev.stop) begin
            st     <= ST_IDLE;
            bitcnt <= '0;
            in_ack <= 1'b0;
            sda_oe <= 1'b0;
        end else if (st != ST_IDLE && st != ST_IGNORE) begin
            if (in_ack) begin
                if (ev.scl_fall) begin
                    sda_oe <= 1'b0;
                    in_ack <= 1'b0;
                    st     <= pend;
                end
            end else if (ev.scl_rise && bitcnt < 4'd8) begin
                shreg  <= {shreg[6:0], ev.sda};
                bitcnt <= bitcnt + 4'd1;
            end else if (byte_done) begin
                bitcnt <= '0;
                if (dec.ack) begin
                    sda_oe <= 1'b1;
                    in_ack <= 1'b1;
                    pend   <= dec.nxt;
                end else begin
                    st <= ST_IGNORE;
                end
                if (st == ST_COUNT) begin
                    remain <= shreg[CW-1:0];
                    idx    <= '0;
                end else if (st == ST_DATA && dec.ack) begin
                    remain <= remain - 1'b1;
                    idx    <= idx + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/cfg_reg_bank.sv
module cfg_reg_bank
    import cfg_pkg::*;
#(
    parameter int NUM_REGS = 6,
    parameter int CW       = 6
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wr_en,
    input  logic [CW-1:0]         wr_idx,
    input  logic [7:0]            wr_data,
    input  logic                  stop_pin_n_i,
    input  logic [1:0]            strap_i,
    output logic [8*NUM_REGS-1:0] cfg_o
);
    logic [1:0] strap_q;

    always_ff @(posedge clk) begin
        if (rst) strap_q <= strap_i;
    end

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
        localparam logic [7:0] WMASK = reg_wmask(g);
        logic [7:0] q;

        always_ff @(posedge clk) begin
            if (rst)
                q <= reg_default(g);
            else if (wr_en && wr_idx == CW'(g))
                q <= (q & ~WMASK) | (wr_data & WMASK);
        end

        if (g == 0) begin : g_status
            assign cfg_o[7:0] = q | {3'b000, stop_pin_n_i, 1'b0, strap_q, 1'b1};
        end else begin : g_plain
            assign cfg_o[8*g +: 8] = q;
        end
    end
endmodule

// File: rtl/clkcfg_smbus_target.sv
module clkcfg_smbus_target
    import cfg_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR  = 7'h69,
    parameter int         MAX_COUNT = 32,
    parameter int         NUM_REGS  = 6,
    parameter int         SYNC_STG  = 2
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  scl_i,
    input  logic                  sda_i,
    output logic                  sda_oe_o,
    input  logic                  stop_pin_n_i,
    input  logic [1:0]            strap_i,
    output logic [8*NUM_REGS-1:0] cfg_o
);
    localparam int CW = $clog2(MAX_COUNT + 1);

    bus_ev_t       ev;
    st_e           eng_st;
    logic          wr_en;
    logic [CW-1:0] wr_idx;
    logic [7:0]    wr_data;

    cfg_bus_sync #(.STAGES(SYNC_STG)) u_sync (
        .clk   (clk),
        .rst   (rst),
        .scl_i (scl_i),
        .sda_i (sda_i),
        .ev    (ev)
    );

    cfg_byte_engine #(
        .DEV_ADDR  (DEV_ADDR),
        .MAX_COUNT (MAX_COUNT),
        .NUM_REGS  (NUM_REGS),
        .CW        (CW)
    ) u_eng (
        .clk     (clk),
        .rst     (rst),
        .ev      (ev),
        .st_o    (eng_st),
        .sda_oe  (sda_oe_o),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_data (wr_data)
    );

    cfg_reg_bank #(.NUM_REGS(NUM_REGS), .CW(CW)) u_regs (
        .clk          (clk),
        .rst          (rst),
        .wr_en        (wr_en),
        .wr_idx       (wr_idx),
        .wr_data      (wr_data),
        .stop_pin_n_i (stop_pin_n_i),
        .strap_i      (strap_i),
        .cfg_o        (cfg_o)
    );
endmodule

// File: rtl/clkcfg_smbus_chk.sv
module clkcfg_smbus_chk
    import cfg_pkg::*;
#(
    parameter int NUM_REGS = 6,
    parameter int CW       = 6
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  scl_i,
    input logic                  sda_oe_o,
    input logic [8*NUM_REGS-1:0] cfg_o,
    input st_e                   st,
    input logic                  wr_en,
    input logic [CW-1:0]         wr_idx
);
    for (genvar g = 1; g < NUM_REGS; g++) begin : g_def
        assert_reset_default_R1: assert property (@(posedge clk) disable iff (rst)
            $past(rst) |-> cfg_o[8*g +: 8] == reg_default(g));
    end

    assert_quiet_when_ignoring_R2: assert property (@(posedge clk) disable iff (rst)
        (st == ST_IGNORE || st == ST_IDLE) |-> !sda_oe_o);

    assert_write_only_in_payload_R5: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> st == ST_DATA);

    assert_write_in_bank_R7: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> int'(wr_idx) < NUM_REGS);

    assert_strap_held_R8: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> $stable(cfg_o[2:1]));

    assert_const_bit0_R8: assert property (@(posedge clk) disable iff (rst)
        cfg_o[0]);

    assert_oe_moves_scl_low_R9: assert property (@(posedge clk) disable iff (rst)
        !$stable(sda_oe_o) |-> !scl_i);
endmodule

bind clkcfg_smbus_target clkcfg_smbus_chk #(.NUM_REGS(NUM_REGS), .CW(CW)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .scl_i    (scl_i),
    .sda_oe_o (sda_oe_o),
    .cfg_o    (cfg_o),
    .st       (eng_st),
    .wr_en    (wr_en),
    .wr_idx   (wr_idx)
);

// File: tb/clkcfg_smbus_target_bench.sv
module clkcfg_smbus_target_bench;
    localparam int NR = 6;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic          rst = 1'b1;
    logic          host_scl = 1'b1, host_sda = 1'b1;
    logic          stop_pin_n = 1'b1;
    logic [1:0]    straps = 2'b10, straps_seen = 2'b10;
    logic          sda_oe;
    logic [8*NR-1:0] cfg;
    wire           sda_line = host_sda & ~sda_oe;

    int n_tests = 0, n_fail = 0;
    logic [7:0] model [NR];

    clkcfg_smbus_target u_clkcfg_smbus_target (
        .clk          (clk),
        .rst          (rst),
        .scl_i        (host_scl),
        .sda_i        (sda_line),
        .sda_oe_o     (sda_oe),
        .stop_pin_n_i (stop_pin_n),
        .strap_i      (straps),
        .cfg_o        (cfg)
    );

    function automatic logic [7:0] b_def(int i);
        logic [7:0] t [NR] = '{8'h00, 8'h07, 8'h7F, 8'hC7, 8'h3F, 8'h00};
        return t[i];
    endfunction

    function automatic logic [7:0] b_mask(int i);
        logic [7:0] t [NR] = '{8'hA8, 8'h7F, 8'h7F, 8'hFF, 8'h3F, 8'h3F};
        return t[i];
    endfunction

    function automatic logic [7:0] pat(int seed, int k);
        return 8'((seed * 29 + k * 71 + 5) ^ (k << 3));
    endfunction

    function automatic logic [7:0] view(int i);
        if (i == 0)
            return (model[0] & 8'hA8) | {3'b000, stop_pin_n, 1'b0, straps_seen, 1'b1};
        return model[i];
    endfunction

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < NR; i++) model[i] = b_def(i);
        straps_seen = straps;
    endtask

    task automatic model_write(input int i, input logic [7:0] d);
        if (i < NR) model[i] = (model[i] & ~b_mask(i)) | (d & b_mask(i));
    endtask

    task automatic chk_regs(input string req);
        for (int i = 0; i < NR; i++)
            chk(cfg[8*i +: 8] == view(i), req, cfg[8*i +: 8], view(i));
    endtask

    task automatic bus_start();
        host_sda = 1'b1; tick(10);
        host_scl = 1'b1; tick(10);
        host_sda = 1'b0; tick(10);
        host_scl = 1'b0; tick(10);
    endtask

    task automatic bus_stop();
        host_sda = 1'b0; tick(10);
        host_scl = 1'b1; tick(10);
        host_sda = 1'b1; tick(20);
    endtask

    task automatic send_chk(input logic [7:0] b, input bit exp_ack, input string req);
        bit acked;
        for (int i = 7; i >= 0; i--) begin
            host_sda = b[i]; tick(10);
            host_scl = 1'b1; tick(20);
            host_scl = 1'b0; tick(10);
        end
        host_sda = 1'b1; tick(10);
        host_scl = 1'b1; tick(10);
        acked = (sda_line == 1'b0);
        tick(10);
        host_scl = 1'b0; tick(10);
        chk(acked == exp_ack, req, acked, exp_ack);
        chk(sda_oe == 1'b0, "R9", sda_oe, 0);
    endtask

    task automatic header(input logic [7:0] cnt);
        send_chk(8'hD2, 1'b1, "R2");
        send_chk(8'h00, 1'b1, "R3");
        send_chk(cnt, 1'b1, "R4");
    endtask

    task automatic write_pattern(input int cnt, input int seed, input int send_n, input string req);
        bus_start();
        header(8'(cnt));
        for (int k = 0; k < send_n; k++) begin
            send_chk(pat(seed, k), k < cnt, (k < cnt) ? ((k < NR) ? "R5" : "R7") : "R7");
            if (k < cnt) model_write(k, pat(seed, k));
        end
        bus_stop();
        chk_regs(req);
    endtask

    task automatic junk_tail(input string req);
        send_chk(8'h00, 1'b0, req);
        send_chk(8'h03, 1'b0, req);
        send_chk(8'hA5, 1'b0, req);
        bus_stop();
        chk_regs(req);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin : main
        logic [7:0] bad_addr [4] = '{8'hD3, 8'hD0, 8'h52, 8'hA4};
        logic [7:0] bad_cmd  [3] = '{8'h01, 8'h80, 8'hFF};
        logic [7:0] bad_cnt  [3] = '{8'h00, 8'h21, 8'hFF};

        rst = 1'b1; tick(5);
        model_reset();
        chk(sda_oe == 1'b0, "R1", sda_oe, 0);
        chk_regs("R1");
        rst = 1'b0; tick(3);
        chk_regs("R1");

        // R5 / R7: count sweep, including counts past the register bank
        for (int c = 1; c <= 8; c++) write_pattern(c, c + 3, c, (c > NR) ? "R7" : "R5");

        // R2: rejected addresses, payload afterwards must be ignored
        foreach (bad_addr[i]) begin
            bus_start();
            send_chk(bad_addr[i], 1'b0, "R2");
            junk_tail("R2");
        end

        // R3: bad command codes
        foreach (bad_cmd[i]) begin
            bus_start();
            send_chk(8'hD2, 1'b1, "R2");
            send_chk(bad_cmd[i], 1'b0, "R3");
            junk_tail("R3");
        end

        // R4: illegal counts, then the maximum legal count
        foreach (bad_cnt[i]) begin
            bus_start();
            send_chk(8'hD2, 1'b1, "R2");
            send_chk(8'h00, 1'b1, "R3");
            send_chk(bad_cnt[i], 1'b0, "R4");
            junk_tail("R4");
        end
        write_pattern(32, 11, 32, "R4");

        // R7: one byte past the count is refused
        write_pattern(2, 17, 3, "R7");

        // R6: early stop keeps acknowledged bytes, next write starts at register 0
        bus_start();
        header(8'd5);
        send_chk(8'h5A, 1'b1, "R6"); model_write(0, 8'h5A);
        send_chk(8'hC3, 1'b1, "R6"); model_write(1, 8'hC3);
        bus_stop();
        chk_regs("R6");
        write_pattern(1, 23, 1, "R6");

        // R10: repeated start in the middle of the header
        bus_start();
        send_chk(8'hD2, 1'b1, "R10");
        send_chk(8'h00, 1'b1, "R10");
        bus_start();
        header(8'd2);
        send_chk(8'h99, 1'b1, "R10"); model_write(0, 8'h99);
        send_chk(8'h66, 1'b1, "R10"); model_write(1, 8'h66);
        bus_stop();
        chk_regs("R10");

        // R10: repeated start after a rejected address recovers
        bus_start();
        send_chk(8'hA4, 1'b0, "R10");
        bus_start();
        header(8'd1);
        send_chk(8'hFF, 1'b1, "R10"); model_write(0, 8'hFF);
        bus_stop();
        chk_regs("R10");

        // R8: live pin and latched straps
        stop_pin_n = 1'b0; tick(2);
        chk(cfg[4] == 1'b0, "R8", cfg[4], 0);
        straps = 2'b01; tick(4);
        chk_regs("R8");
        stop_pin_n = 1'b1; tick(2);
        chk(cfg[4] == 1'b1, "R8", cfg[4], 1);

        // R1 / R8: second reset restores defaults and captures new straps
        rst = 1'b1; tick(4);
        rst = 1'b0; tick(2);
        model_reset();
        chk_regs("R1");
        chk(cfg[2:1] == 2'b01, "R8", cfg[2:1], 2'b01);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule